// File: doc/BRIEF.md
# Dual 40-bit saturating accumulator

This block holds two 40-bit accumulators, A and B, and one shared 40-bit adder/subtracter. On each cycle with an operation requested, one accumulator is selected; it is both the source and the destination. The other input is a 40-bit operand that the caller has already sign-extended and shifted. The operation adds the operand, subtracts it, or loads it, with the accumulator side of the adder forced to zero for a load. The upper eight bits, 39 down to 32, are guard bits above a 32-bit working value.

Every operation updates a guard-overflow flag for the destination. Saturation can be enabled separately for each accumulator. The clamp point is selected between the 32-bit working range (normal mode) and the full 40-bit range (super mode). Saturation events set per-accumulator flags that stay set until they are cleared. Two combined flags and a trap request are derived from the per-accumulator flags. The trap request is qualified by per-accumulator enables and goes to an external trap controller.

Top module: `dual_sat_acc`

## Requirements
- R1: After reset both accumulators are zero, all four flags and both combined flags are low, and `trap_req` is low.
- R2: An operation with `op_sub`=0 and `op_zero`=0 writes (destination + operand) mod 2^40 into the accumulator chosen by `acc_sel` (0 selects A, 1 selects B). The other accumulator and its flags do not change.
- R3: With `op_sub`=1 and `op_zero`=0, the destination becomes (destination − operand) mod 2^40. The adder forms this from the complemented operand with a carry-in of one.
- R4: With `op_zero`=1, the accumulator side of the adder reads zero, so the destination is loaded with the operand (`op_sub`=0) or with its negation (`op_sub`=1).
- R5: Every operation rewrites the destination's guard-overflow flag. The flag is 1 exactly when bits 39 down to 31 of the unsaturated 40-bit adder result are not all equal.
- R6: When the destination's saturation enable is low, the result wraps to 40 bits and the destination's saturation flag is not set, even on overflow.
- R7: In normal mode (`sat_super`=0) with saturation enabled, the result is clamped in two cases: the raw result shows guard overflow, or the exact result lies outside the 40-bit signed range. The clamp is 0x007FFFFFFF for a positive exact result and 0xFF80000000 for a negative one, and the destination's saturation flag is set.
- R8: In super mode (`sat_super`=1) with saturation enabled, guard overflow alone passes through unclamped. Only an exact result outside the 40-bit signed range is clamped, to 0x7FFFFFFFFF or 0x8000000000 according to the sign of the exact result, and the saturation flag is set.
- R9: Saturation flags are sticky. `sat_clr` clears both of them. A saturation in the same cycle as `sat_clr` leaves that accumulator's flag set.
- R10: `ovf_any` equals `ovf_a` OR `ovf_b`, and `sat_any` equals `sat_a` OR `sat_b`.
- R11: `trap_req` is high exactly when (`ovf_a` AND `trap_en_a`) OR (`ovf_b` AND `trap_en_b`).
- R12: In a cycle with `op_valid`=0, neither accumulator nor guard-overflow flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Perform an operation this cycle |
| acc_sel | input | 1 | Destination/source: 0 = A, 1 = B |
| op_sub | input | 1 | 1 = subtract operand, 0 = add |
| op_zero | input | 1 | Force accumulator side of the adder to zero (load) |
| operand | input | ACC_W | Pre-extended, pre-shifted operand |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_super | input | 1 | 0 = clamp at 32-bit range, 1 = clamp at 40-bit range |
| trap_en_a | input | 1 | Trap enable for A guard overflow |
| trap_en_b | input | 1 | Trap enable for B guard overflow |
| sat_clr | input | 1 | Clear both saturation flags |
| acc_a | output | ACC_W | Accumulator A |
| acc_b | output | ACC_W | Accumulator B |
| ovf_a | output | 1 | A guard-overflow flag |
| ovf_b | output | 1 | B guard-overflow flag |
| sat_a | output | 1 | A sticky saturation flag |
| sat_b | output | 1 | B sticky saturation flag |
| ovf_any | output | 1 | OR of guard-overflow flags |
| sat_any | output | 1 | OR of saturation flags |
| trap_req | output | 1 | Arithmetic trap request |

## Verification
The bench pairs sixteen corner values, namely the range limits, the guard boundaries, ±1 and mixed patterns, on both the accumulator side and the operand side. Each pair is run as add and subtract, in each saturation setting, against an arithmetic model with exact precision. The runs target the sign choice on a carry out of the top bit, where a design that takes the sign from the truncated result clamps to the wrong rail. They also target super mode passing guard overflow through, which a design that saturates on guard overflow in every mode would clamp. Other cases cover a subtract of the most negative value, which fails without the exact carry-in, and a saturation enable taken from the wrong accumulator. Directed cases check that a saturation in the clearing cycle survives the clear, and that the flags of the unselected accumulator hold.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
    typedef enum logic {
        ACC_SEL_A = 1'b0,
        ACC_SEL_B = 1'b1
    } acc_sel_e;

    localparam int NUM_ACC = 2;
endpackage

// File: rtl/dsa_addsub.sv
module dsa_addsub #(
    parameter int W  = 40,
    parameter int WK = 32
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] opd_i,
    input  logic         zero_i,
    input  logic         sub_i,
    output logic [W:0]   sum_o,
    output logic         guard_ovf_o,
    output logic         cat_ovf_o
);
    localparam int GSPAN = W - WK + 1;

    logic [W-1:0]   lhs;
    logic [W-1:0]   rhs;
    logic [GSPAN-1:0] top_bits;

    always_comb begin
        lhs         = zero_i ? '0 : src_i;
        rhs         = sub_i ? ~opd_i : opd_i;
        // one extra bit keeps the exact sign of the result
        sum_o       = {lhs[W-1], lhs} + {rhs[W-1], rhs} + {{W{1'b0}}, sub_i};
        top_bits    = sum_o[W-1:WK-1];
        guard_ovf_o = !((top_bits == '0) || (top_bits == '1));
        cat_ovf_o   = sum_o[W] ^ sum_o[W-1];
    end
endmodule

// File: rtl/dsa_sat.sv
module dsa_sat #(
    parameter int W  = 40,
    parameter int WK = 32
) (
    input  logic [W:0]   sum_i,
    input  logic         guard_ovf_i,
    input  logic         cat_ovf_i,
    input  logic         sat_en_i,
    input  logic         super_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] NORM_POS = {{(W - WK + 1){1'b0}}, {(WK - 1){1'b1}}};
    localparam logic [W-1:0] NORM_NEG = ~NORM_POS;
    localparam logic [W-1:0] SUP_POS  = {1'b0, {(W - 1){1'b1}}};
    localparam logic [W-1:0] SUP_NEG  = ~SUP_POS;

    logic exact_neg;

    always_comb begin
        exact_neg = sum_i[W];
        sat_o     = sat_en_i & (cat_ovf_i | (~super_i & guard_ovf_i));
        if (!sat_o) begin
            res_o = sum_i[W-1:0];
        end else if (super_i) begin
            res_o = exact_neg ? SUP_NEG : SUP_POS;
        end else begin
            res_o = exact_neg ? NORM_NEG : NORM_POS;
        end
    end
endmodule

// File: rtl/dual_sat_acc.sv
module dual_sat_acc
    import dsa_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int WORK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             acc_sel,
    input  logic             op_sub,
    input  logic             op_zero,
    input  logic [ACC_W-1:0] operand,
    input  logic             sat_en_a,
    input  logic             sat_en_b,
    input  logic             sat_super,
    input  logic             trap_en_a,
    input  logic             trap_en_b,
    input  logic             sat_clr,
    output logic [ACC_W-1:0] acc_a,
    output logic [ACC_W-1:0] acc_b,
    output logic             ovf_a,
    output logic             ovf_b,
    output logic             sat_a,
    output logic             sat_b,
    output logic             ovf_any,
    output logic             sat_any,
    output logic             trap_req
);
    localparam int GSPAN = ACC_W - WORK_W + 1;

    typedef struct packed {
        logic [NUM_ACC-1:0][ACC_W-1:0] acc;
        logic [NUM_ACC-1:0]            ovf;
        logic [NUM_ACC-1:0]            sat;
    } state_t;

    state_t state_d, state_q;

    acc_sel_e         sel_e;
    logic [ACC_W-1:0] src_val;
    logic [ACC_W:0]   sum_val;
    logic             guard_ovf, cat_ovf;
    logic             sel_sat_en, sat_hit;
    logic [ACC_W-1:0] res_val;

    assign sel_e      = acc_sel_e'(acc_sel);
    assign src_val    = state_q.acc[acc_sel];
    assign sel_sat_en = (sel_e == ACC_SEL_B) ? sat_en_b : sat_en_a;

    dsa_addsub #(.W(ACC_W), .WK(WORK_W)) i_addsub (
        .src_i       (src_val),
        .opd_i       (operand),
        .zero_i      (op_zero),
        .sub_i       (op_sub),
        .sum_o       (sum_val),
        .guard_ovf_o (guard_ovf),
        .cat_ovf_o   (cat_ovf)
    );

    dsa_sat #(.W(ACC_W), .WK(WORK_W)) i_sat (
        .sum_i       (sum_val),
        .guard_ovf_i (guard_ovf),
        .cat_ovf_i   (cat_ovf),
        .sat_en_i    (sel_sat_en),
        .super_i     (sat_super),
        .res_o       (res_val),
        .sat_o       (sat_hit)
    );

    always_comb begin
        state_d = state_q;
        if (sat_clr) begin
            state_d.sat = '0;
        end
        if (op_valid) begin
            state_d.acc[acc_sel] = res_val;
            state_d.ovf[acc_sel] = guard_ovf;
            if (sat_hit) begin
                state_d.sat[acc_sel] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_a    = state_q.acc[0];
    assign acc_b    = state_q.acc[1];
    assign ovf_a    = state_q.ovf[0];
    assign ovf_b    = state_q.ovf[1];
    assign sat_a    = state_q.sat[0];
    assign sat_b    = state_q.sat[1];
    assign ovf_any  = |state_q.ovf;
    assign sat_any  = |state_q.sat;
    assign trap_req = |(state_q.ovf & {trap_en_b, trap_en_a});

    assert_unsel_b_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel) |=> ($stable(acc_b) && $stable(ovf_b)));

    assert_unsel_a_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_sel) |=> ($stable(acc_a) && $stable(ovf_a)));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b) && $stable(ovf_a) && $stable(ovf_b)));

    assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_a && !sat_clr) |=> sat_a);

    assert_sat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !op_valid) |=> (!sat_a && !sat_b));

    assert_norm_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel && sat_en_a && !sat_super)
        |=> (acc_a[ACC_W-1:WORK_W-1] == {GSPAN{acc_a[ACC_W-1]}}));

    assert_no_sat_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel && !sat_en_a && !sat_a) |=> !sat_a);
endmodule

// File: tb/test_dual_sat_acc.sv
module test_dual_sat_acc;
    localparam int W  = 12;
    localparam int WK = 8;
    localparam longint MAXV = (longint'(1) << (W - 1)) - 1;
    localparam longint MINV = -(longint'(1) << (W - 1));
    localparam logic [W-1:0] NPOS = W'((longint'(1) << (WK - 1)) - 1);
    localparam logic [W-1:0] NNEG = W'(-(longint'(1) << (WK - 1)));
    localparam logic [W-1:0] SPOS = W'(MAXV);
    localparam logic [W-1:0] SNEG = W'(MINV);
    localparam logic [W-1:0] PATS [16] = '{12'h000, 12'h001, 12'h07F, 12'h080,
        12'h0FF, 12'h7FF, 12'h800, 12'hF80, 12'hF7F, 12'hFFF, 12'h3A5, 12'hC5B,
        12'h100, 12'h7F0, 12'h801, 12'hFFE};

    logic clk = 0, rst_n = 0;
    logic op_valid = 0, acc_sel = 0, op_sub = 0, op_zero = 0;
    logic [W-1:0] operand = '0;
    logic sat_en_a = 0, sat_en_b = 0, sat_super = 0;
    logic trap_en_a = 0, trap_en_b = 0, sat_clr = 0;
    logic [W-1:0] acc_a, acc_b;
    logic ovf_a, ovf_b, sat_a, sat_b, ovf_any, sat_any, trap_req;

    int n_run = 0, n_fail = 0;
    logic [W-1:0] m_acc [2];
    logic m_ovf [2];
    logic m_sat [2];

    always #10 clk = ~clk;

    dual_sat_acc #(.ACC_W(W), .WORK_W(WK)) i_dual_sat_acc (.*);

    function automatic longint sx(logic [W-1:0] v);
        return v[W-1] ? longint'(v) - (longint'(1) << W) : longint'(v);
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_all(string vtag);
        chk(vtag, 64'(acc_a), 64'(m_acc[0]));
        chk(vtag, 64'(acc_b), 64'(m_acc[1]));
        chk("R5 ovf_a", 64'(ovf_a), 64'(m_ovf[0]));
        chk("R5 ovf_b", 64'(ovf_b), 64'(m_ovf[1]));
        chk("R9 sat_a", 64'(sat_a), 64'(m_sat[0]));
        chk("R9 sat_b", 64'(sat_b), 64'(m_sat[1]));
        chk("R10 ovf_any", 64'(ovf_any), 64'(m_ovf[0] | m_ovf[1]));
        chk("R10 sat_any", 64'(sat_any), 64'(m_sat[0] | m_sat[1]));
        chk("R11 trap_req", 64'(trap_req),
            64'((m_ovf[0] & trap_en_a) | (m_ovf[1] & trap_en_b)));
    endtask

    task automatic do_op(logic sel, logic sub, logic zero, logic [W-1:0] opd,
                         logic sat_on, logic superm, logic clr);
        longint a, t;
        logic [63:0] tv;
        logic [W-1:0] raw, val;
        logic guard, cat, hit;
        string vtag;
        @(negedge clk);
        op_valid = 1; acc_sel = sel; op_sub = sub; op_zero = zero; operand = opd;
        sat_en_a = sel ? !sat_on : sat_on;
        sat_en_b = sel ? sat_on : !sat_on;
        sat_super = superm; sat_clr = clr;
        @(negedge clk);
        op_valid = 0; sat_clr = 0;
        a = zero ? 0 : sx(m_acc[sel]);
        t = sub ? a - sx(opd) : a + sx(opd);
        tv = 64'(t);
        raw = tv[W-1:0];
        guard = !((raw[W-1:WK-1] == '0) || (raw[W-1:WK-1] == '1));
        cat = (t > MAXV) || (t < MINV);
        hit = sat_on && (cat || (!superm && guard));
        if (!hit) val = raw;
        else if (superm) val = (t < 0) ? SNEG : SPOS;
        else val = (t < 0) ? NNEG : NPOS;
        if (sat_on && superm && (guard || cat)) vtag = "R8 value";
        else if (hit) vtag = "R7 value";
        else if (!sat_on && (guard || cat)) vtag = "R6 value";
        else if (zero) vtag = "R4 value";
        else if (sub) vtag = "R3 value";
        else vtag = "R2 value";
        if (clr) begin m_sat[0] = 0; m_sat[1] = 0; end
        m_acc[sel] = val;
        m_ovf[sel] = guard;
        if (hit) m_sat[sel] = 1;
        check_all(vtag);
    endtask

    task automatic idle(logic clr, logic [W-1:0] junk);
        @(negedge clk);
        op_valid = 0; op_zero = 1; op_sub = 1; operand = junk; sat_clr = clr;
        sat_en_a = 1; sat_en_b = 1;
        @(negedge clk);
        sat_clr = 0;
        if (clr) begin m_sat[0] = 0; m_sat[1] = 0; end
        check_all("R12 idle");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 2; i++) begin
            m_acc[i] = '0; m_ovf[i] = 0; m_sat[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");

        // sweep: load, then one arithmetic op on the loaded accumulator
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                for (int m = 0; m < 6; m++) begin
                    logic sel;
                    sel = logic'((i + j + m) & 1);
                    trap_en_a = logic'(((i + m) >> 1) & 1);
                    trap_en_b = logic'((j >> 1) & 1);
                    do_op(sel, 1'b0, 1'b1, PATS[i], 1'b0, 1'b0, 1'b1);
                    do_op(sel, logic'(m & 1), 1'b0, PATS[j],
                          logic'(m >= 2), logic'(m >= 4), 1'b0);
                end
            end
        end

        // R4 negating load
        do_op(1'b0, 1'b1, 1'b1, 12'h005, 1'b0, 1'b0, 1'b0);
        do_op(1'b1, 1'b1, 1'b1, 12'h800, 1'b1, 1'b1, 1'b0);

        // R12 idle with junk inputs
        idle(1'b0, 12'hABC);

        // R9 sticky flag, clear with simultaneous saturation, plain clear
        do_op(1'b0, 1'b0, 1'b1, NPOS, 1'b0, 1'b0, 1'b1);
        do_op(1'b0, 1'b0, 1'b0, 12'h001, 1'b1, 1'b0, 1'b0);
        do_op(1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0);
        do_op(1'b0, 1'b0, 1'b0, 12'h001, 1'b1, 1'b0, 1'b1);
        idle(1'b1, 12'h000);

        // R11 trap with both enables
        trap_en_a = 1; trap_en_b = 1;
        do_op(1'b1, 1'b0, 1'b1, 12'h400, 1'b0, 1'b0, 1'b0);
        trap_en_b = 0;
        idle(1'b0, 12'h000);

        disable watchdog;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule